// File: doc/BRIEF.md
# Link Startup Latency Meter

This block times how long a two-link receive path takes to deliver its first user data after both links leave synchronisation. Each receive link drives an active-low sync request. The two requests are merged into one combined release, which is true only when both links have released. Counting begins on the rising edge of that combined release. It stops at the first cycle in which the link-valid strobe is seen high.

The result is a count of link-clock cycles. It stays frozen and readable once the measurement ends. The count is compared across power cycles to confirm that startup latency is deterministic. A known-good setup gives a fixed value, such as 67 cycles.

One measurement is taken per bring-up. A new sync request from either link re-arms the block. A sync request that arrives during counting aborts the measurement. The counter saturates instead of wrapping and raises an overflow flag. The sync inputs pass through a synchroniser of parameterised depth (`SYNC_STAGES`, default 2). All timing below uses S for that depth.

Top module: `link_latency_meter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `latCount` is 0 and `measDone`, `measBusy` and `measOvf` are 0.
- R2: Releasing only one sync input (driving it high while the other stays low) never starts a measurement: `measBusy` stays 0.
- R3: A measurement starts when both sync inputs are high after the combined release had been seen low. If both are high before clock edge P0, `measBusy` is 0 after edge P(S-1) and 1 after edge P(S).
- R4: If `linkValid` is first driven high before edge P(d), the final count is d-S-1 for d > S+1, and 0 otherwise.
- R5: On the edge where `linkValid` is sampled high during a measurement, `measDone` becomes 1, `measBusy` becomes 0 and `latCount` freezes.
- R6: While `measDone` is 1 and both syncs stay released, activity on `linkValid` changes neither `latCount` nor `measDone`.
- R7: If either sync input goes low during a measurement, the measurement aborts. Within S+1 cycles `measBusy` is 0, `measDone` is 0 and `latCount` is 0.
- R8: A sync request after a completed measurement clears `measDone` but keeps `latCount` until the next start. `linkValid` has no effect while no measurement is running.
- R9: The count saturates at 2^CNT_W-1. `measOvf` is set when a further increment is needed, and both are cleared at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous link-domain reset, active high |
| syncReqNA | input | 1 | Sync request of link A, active low |
| syncReqNB | input | 1 | Sync request of link B, active low |
| linkValid | input | 1 | Marks the first user data output |
| latCount | output | CNT_W | Measured latency in link cycles |
| measDone | output | 1 | Measurement finished, count frozen |
| measBusy | output | 1 | Measurement in progress |
| measOvf | output | 1 | Count saturated |

## Verification
The assertions take for granted three things about the inputs. The sync requests change at most once per link cycle. The sync requests are in step with the link clock after the synchroniser. `linkValid` needs no synchronisation because it already lives in the link domain.

The bench meets these assumptions by driving every input on the falling clock edge. It holds each sync level for whole cycles and lowers both sync inputs between measurements so that each release is a clean edge. Random trials draw the link-valid delay and a lead of one link over the other. Directed cases cover zero delay, the start-up boundary, an abort, re-arming and saturation.

// File: rtl/slm_pkg.sv
package slm_pkg;
  // Measurement phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } measState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic clr;  // zero the count and the overflow flag
    logic inc;  // advance the count by one (saturating)
  } cntStrobe_t;
endpackage

// File: rtl/slm_sync.sv
module slm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] shReg;
      always_ff @(posedge clk) begin
        if (rst) begin
          shReg <= {STAGES{RST_VAL}};
        end else begin
          shReg[0] <= din;
          for (int i = 1; i < STAGES; i++) begin
            shReg[i] <= shReg[i-1];
          end
        end
      end
      assign dout = shReg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/slm_ctrl.sv
module slm_ctrl
  import slm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       syncReqNA,
  input  logic       syncReqNB,
  input  logic       linkValid,
  output cntStrobe_t stb,
  output logic       measDone,
  output logic       measBusy
);
  logic syncRelA;
  logic syncRelB;
  logic relNow;
  logic relPrev;
  logic relEdge;
  measState_t stCur;
  measState_t stNxt;

  slm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncA (
    .clk(clk), .rst(rst), .din(syncReqNA), .dout(syncRelA)
  );
  slm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncB (
    .clk(clk), .rst(rst), .din(syncReqNB), .dout(syncRelB)
  );

  // Combined release: both links have dropped their request
  assign relNow = syncRelA & syncRelB;

  always_ff @(posedge clk) begin
    if (rst) relPrev <= 1'b1;
    else     relPrev <= relNow;
  end

  assign relEdge = relNow & ~relPrev;

  always_comb begin
    stNxt   = stCur;
    stb.clr = 1'b0;
    stb.inc = 1'b0;
    case (stCur)
      ST_IDLE: begin
        if (relEdge) begin
          stNxt   = ST_COUNT;
          stb.clr = 1'b1;
        end
      end
      ST_COUNT: begin
        if (!relNow) begin
          stNxt   = ST_IDLE;
          stb.clr = 1'b1;
        end else if (linkValid) begin
          stNxt = ST_DONE;
        end else begin
          stb.inc = 1'b1;
        end
      end
      ST_DONE: begin
        if (!relNow) stNxt = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stCur <= ST_IDLE;
    else     stCur <= stNxt;
  end

  assign measBusy = (stCur == ST_COUNT);
  assign measDone = (stCur == ST_DONE);

  // R4
  keep_counting_chk: assert property (@(posedge clk) disable iff (rst)
    measBusy && relNow && !linkValid |=> measBusy);

  // R5
  stop_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
    measBusy && relNow && linkValid |=> measDone && !measBusy);

  // R7
  abort_on_request_chk: assert property (@(posedge clk) disable iff (rst)
    measBusy && !relNow |=> !measBusy && !measDone);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    measDone && relNow |=> measDone);

  // R2
  single_link_chk: assert property (@(posedge clk) disable iff (rst)
    !measBusy && !(syncRelA && syncRelB) |=> !measBusy);
endmodule

// File: rtl/slm_dpath.sv
module slm_dpath
  import slm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrobe_t       stb,
  output logic [CNT_W-1:0] latCount,
  output logic             cntOvf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      latCount <= '0;
      cntOvf   <= 1'b0;
    end else if (stb.clr) begin
      latCount <= '0;
      cntOvf   <= 1'b0;
    end else if (stb.inc) begin
      if (latCount == CNT_MAX) cntOvf   <= 1'b1;
      else                     latCount <= latCount + 1'b1;
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stb.clr && stb.inc));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cntOvf |-> latCount == CNT_MAX);

  // R4
  monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.clr |=> latCount >= $past(latCount));
endmodule

// File: rtl/link_latency_meter.sv
module link_latency_meter
  import slm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             syncReqNA,
  input  logic             syncReqNB,
  input  logic             linkValid,
  output logic [CNT_W-1:0] latCount,
  output logic             measDone,
  output logic             measBusy,
  output logic             measOvf
);
  cntStrobe_t stb;

  slm_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst),
    .syncReqNA(syncReqNA), .syncReqNB(syncReqNB), .linkValid(linkValid),
    .stb(stb), .measDone(measDone), .measBusy(measBusy)
  );

  slm_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb),
    .latCount(latCount), .cntOvf(measOvf)
  );

  // R6
  frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
    measDone |=> !measDone || $stable(latCount));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> latCount == '0 && !measDone && !measBusy && !measOvf);
endmodule

// File: tb/link_latency_meter_tb.sv
module link_latency_meter_tb;
  localparam int CW  = 12;
  localparam int SS  = 2;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst;
  logic syncReqNA, syncReqNB, linkValid;
  logic [CW-1:0] latCount;
  logic measDone, measBusy, measOvf;
  int total = 0;
  int bad = 0;
  int lastCnt = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  link_latency_meter #(.CNT_W(CW), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst(rst), .syncReqNA(syncReqNA), .syncReqNB(syncReqNB),
    .linkValid(linkValid), .latCount(latCount), .measDone(measDone),
    .measBusy(measBusy), .measOvf(measOvf)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRaw(input int d);
    return (d > SS + 1) ? d - SS - 1 : 0;
  endfunction

  function automatic int expCnt(input int d);
    return (expRaw(d) > MAXV) ? MAXV : expRaw(d);
  endfunction

  function automatic int expOvf(input int d);
    return (expRaw(d) > MAXV) ? 1 : 0;
  endfunction

  task automatic lowerAll();
    syncReqNA = 1'b0;
    syncReqNB = 1'b0;
    linkValid = 1'b0;
    step(SS + 3);
  endtask

  // Both syncs low on entry; link A may lead link B by some cycles
  task automatic measure(input int d, input int lead);
    int last;
    syncReqNA = 1'b1;
    if (lead > 0) begin
      step(lead);
      chk("R2 lead busy", int'(measBusy), 0);
    end
    syncReqNB = 1'b1;
    if (d == 0) linkValid = 1'b1;
    last = ((d > SS + 1) ? d : SS + 1) + 1;
    for (int k = 1; k <= last; k++) begin
      step(1);
      if (k == SS)     chk("R3 busy before start", int'(measBusy), 0);
      if (k == SS + 1) chk("R3 busy after start", int'(measBusy), 1);
      if (k == d)      linkValid = 1'b1;
    end
    chk("R5 done", int'(measDone), 1);
    chk("R5 busy", int'(measBusy), 0);
    chk("R4 count", int'(latCount), expCnt(d));
    chk("R9 ovf", int'(measOvf), expOvf(d));
    lastCnt = expCnt(d);
  endtask

  initial begin
    rst = 1'b1;
    syncReqNA = 1'b0;
    syncReqNB = 1'b0;
    linkValid = 1'b0;
    void'($urandom(32'd4242));
    step(3);
    chk("R1 count", int'(latCount), 0);
    chk("R1 done", int'(measDone), 0);
    chk("R1 busy", int'(measBusy), 0);
    chk("R1 ovf", int'(measOvf), 0);
    rst = 1'b0;
    step(1);
    chk("R1 busy after release", int'(measBusy), 0);
    step(SS + 2);

    // R2: only one link released
    syncReqNA = 1'b1;
    step(10);
    chk("R2 one link busy", int'(measBusy), 0);
    syncReqNA = 1'b0;
    syncReqNB = 1'b1;
    step(10);
    chk("R2 other link busy", int'(measBusy), 0);
    lowerAll();

    // Known-good latency value
    measure(67 + SS + 1, 0);
    chk("R4 known value", int'(latCount), 67);

    // R6: link-valid toggling after done
    for (int i = 0; i < 6; i++) begin
      linkValid = ~linkValid;
      step(1);
    end
    chk("R6 count frozen", int'(latCount), 67);
    chk("R6 done held", int'(measDone), 1);

    // R8: re-arm keeps count, idle link-valid ignored
    lowerAll();
    chk("R8 done cleared", int'(measDone), 0);
    chk("R8 count kept", int'(latCount), 67);
    linkValid = 1'b1;
    step(6);
    chk("R8 idle valid busy", int'(measBusy), 0);
    chk("R8 idle valid count", int'(latCount), 67);
    lowerAll();

    // Boundary delays
    measure(0, 0);   lowerAll();
    measure(SS + 1, 0); lowerAll();
    measure(SS + 2, 0); lowerAll();

    // R7: abort
    syncReqNA = 1'b1;
    syncReqNB = 1'b1;
    step(10);
    chk("R7 busy before abort", int'(measBusy), 1);
    syncReqNB = 1'b0;
    step(SS + 1);
    chk("R7 busy", int'(measBusy), 0);
    chk("R7 done", int'(measDone), 0);
    chk("R7 count", int'(latCount), 0);
    lowerAll();

    // R9: saturation, then cleared on next start
    measure(MAXV + SS + 9, 0);
    lowerAll();
    measure(12, 1);
    lowerAll();

    // Random trials
    for (int t = 0; t < 25; t++) begin
      measure(int'($urandom_range(0, 120)), int'($urandom_range(0, 4)));
      lowerAll();
      chk("R8 random count kept", int'(latCount), lastCnt);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule